// File: doc/BRIEF.md
# Segmented 32-bit Outbound Window Translator

This block decodes CPU-side addresses against a single outbound window that feeds a 32-bit bus address space. The window is a naturally aligned power of two, from 256 bytes up to 4 GiB. Its size is programmed as a log2 value. An address whose bits at and above the window size match the window base is a hit. For a hit, the block keeps the offset bits below the window size and fills the bits above them, up to bit 31, from a programmable upper value. The result is a 32-bit bus address.

The window is also cut into 256 equal segments. A 256-entry table, loaded through a one-entry-per-cycle write port, gives each segment an isolation domain number. Each hit reports the domain of the segment it falls in. Results come out one clock after the request, with a hit flag, the bus address and the domain number. Forwarding the access downstream is left to the surrounding logic.

Top module: `seg_window_xlate`

## Requirements
- R1: After reset `out_valid` and `out_hit` are low, `out_dom` is zero, and every table entry reads as zero until it is written.
- R2: `out_valid` in a cycle equals `in_valid` of the previous cycle. Back-to-back requests each produce one result, in order.
- R3: A valid request hits when `in_addr` bits from `cfg_log2sz` upward equal the same bits of `cfg_base`. The base bits below `cfg_log2sz` are ignored. `cfg_log2sz` is legal from 8 to 32.
- R4: On a hit, `out_addr` bits below `cfg_log2sz` are the same bits of `in_addr`. `out_addr` bits from `cfg_log2sz` to 31 are the same bits of `cfg_upper`, and the lower bits of `cfg_upper` are ignored.
- R5: On a hit, the segment index is `in_addr` bits [`cfg_log2sz`-1 : `cfg_log2sz`-8], which makes each segment 1/256 of the window (8 MiB for a 2 GiB window). `out_dom` is the table entry at that index.
- R6: When `tbl_we` is high at a clock edge, the table entry at `tbl_idx` takes `tbl_dom`. A lookup captured at the same edge returns the entry's previous value.
- R7: A valid request that misses gives `out_hit` low, `out_dom` zero and `out_addr` zero.
- R8: The top 64 KiB of the bus range (0xFFFF_0000 to 0xFFFF_FFFF) is not excluded. Hits there are translated like any other address.
- R9: With `cfg_log2sz` = 32, `out_addr` equals `in_addr[31:0]` and `cfg_upper` has no effect. The segment index is `in_addr[31:24]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | ADDR_W | Window base in CPU address space |
| cfg_log2sz | input | 6 | log2 of the window size, 8 to 32 |
| cfg_upper | input | 32 | Value placed above the offset in the bus address |
| tbl_we | input | 1 | Domain table write strobe |
| tbl_idx | input | 8 | Segment index to write |
| tbl_dom | input | DOM_W | Domain number to store |
| in_valid | input | 1 | Request valid |
| in_addr | input | ADDR_W | CPU address of the request |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_hit | output | 1 | Request fell inside the window |
| out_addr | output | 32 | Translated bus address (zero on a miss) |
| out_dom | output | DOM_W | Domain of the hit segment (zero on a miss) |

## Verification
A 2 GiB window at bus address 0x8000_0000 is probed at its first and second segments, at its last segment inside the top 64 KiB, just below the base, and at an alias with a differing high CPU bit. These probes separate the segment slicing from the compare width. A 16 MiB window is tried with junk in the low bits of the base and of the upper value, which shows whether those bits are ignored. A 4 GiB window and a 256-byte window check both ends of the size range, where the upper fill and the index shift are at their limits. A table write in the same cycle as a lookup of that entry separates old-value reads from write-through reads, and back-to-back requests with idle gaps test the latency.

// File: rtl/seg_window_xlate.sv
module seg_window_xlate #(
  parameter int ADDR_W = 48,
  parameter int DOM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [5:0]        cfg_log2sz,
  input  logic [31:0]       cfg_upper,
  input  logic              tbl_we,
  input  logic [7:0]        tbl_idx,
  input  logic [DOM_W-1:0]  tbl_dom,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  output logic              out_hit,
  output logic [31:0]       out_addr,
  output logic [DOM_W-1:0]  out_dom
);
  localparam int SEG_BITS = 8;
  localparam int SEG_N    = 1 << SEG_BITS;

  logic [ADDR_W-1:0] win_mask;
  logic [31:0]       low_mask;
  logic [5:0]        seg_sh;
  logic              hit_c;
  logic [7:0]        seg_c;
  logic [31:0]       addr_c;
  logic [DOM_W-1:0]  dom_tbl [SEG_N];

  assign win_mask = (ADDR_W'(1) << cfg_log2sz) - ADDR_W'(1);
  assign low_mask = win_mask[31:0];
  assign seg_sh   = cfg_log2sz - 6'(SEG_BITS);
  assign hit_c    = in_valid && ((in_addr & ~win_mask) == (cfg_base & ~win_mask));
  assign seg_c    = SEG_BITS'((in_addr & win_mask) >> seg_sh);
  assign addr_c   = (in_addr[31:0] & low_mask) | (cfg_upper & ~low_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SEG_N; i++) dom_tbl[i] <= '0;
    end else if (tbl_we) begin
      dom_tbl[tbl_idx] <= tbl_dom;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_addr  <= '0;
      out_dom   <= '0;
    end else begin
      out_valid <= in_valid;
      out_hit   <= hit_c;
      out_addr  <= hit_c ? addr_c : '0;
      out_dom   <= hit_c ? dom_tbl[seg_c] : '0;
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hit_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit |-> out_valid);
  assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_dom == '0 && out_addr == '0));
  assert_upper_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit |-> ((out_addr & ~$past(low_mask)) == ($past(cfg_upper) & ~$past(low_mask))));
  assert_table_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |=> dom_tbl[$past(tbl_idx)] == $past(tbl_dom));
endmodule

// File: tb/seg_window_xlate_tb.sv
module seg_window_xlate_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [47:0] cfg_base = '0;
  logic [5:0]  cfg_log2sz = 6'd31;
  logic [31:0] cfg_upper = '0;
  logic        tbl_we = 0;
  logic [7:0]  tbl_idx = '0;
  logic [7:0]  tbl_dom = '0;
  logic        in_valid = 0;
  logic [47:0] in_addr = '0;
  logic        out_valid, out_hit;
  logic [31:0] out_addr;
  logic [7:0]  out_dom;

  int checks = 0, errors = 0;
  logic [7:0] shadow [256];
  logic [40:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  seg_window_xlate #(.ADDR_W(48), .DOM_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_log2sz(cfg_log2sz),
    .cfg_upper(cfg_upper), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_dom(tbl_dom),
    .in_valid(in_valid), .in_addr(in_addr), .out_valid(out_valid), .out_hit(out_hit),
    .out_addr(out_addr), .out_dom(out_dom));

  function automatic logic [40:0] model(input logic [47:0] a);
    int lg = int'(cfg_log2sz);
    logic [47:0] off;
    logic [31:0] ba;
    logic [7:0]  seg;
    if ((a >> lg) != (cfg_base >> lg)) return '0;
    off = a - ((a >> lg) << lg);
    ba  = ((cfg_upper >> lg) << lg) | off[31:0];
    seg = 8'(off >> (lg - 8));
    return {1'b1, ba, shadow[seg]};
  endfunction

  task automatic drive(input logic [47:0] a, input string tag);
    @(negedge clk);
    in_valid = 1;
    in_addr  = a;
    exp_q.push_back(model(a));
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic wr(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk);
    in_valid = 0;
    tbl_we = 1; tbl_idx = idx; tbl_dom = d;
    @(negedge clk);
    tbl_we = 0;
    shadow[idx] = d;
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && out_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2: unexpected out_valid, actual 1 expected 0");
      end else begin
        logic [40:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({out_hit, out_addr, out_dom} !== e) begin
          errors++;
          $display("FAIL %s: actual hit=%0b addr=%h dom=%h expected hit=%0b addr=%h dom=%h",
                   t, out_hit, out_addr, out_dom, e[40], e[39:8], e[7:0]);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (out_valid !== 0 || out_hit !== 0 || out_dom !== 0) begin
      errors++;
      $display("FAIL R1: actual v=%0b h=%0b d=%h expected 0 0 00", out_valid, out_hit, out_dom);
    end

    cfg_base = 48'h0_8000_0000; cfg_log2sz = 6'd31; cfg_upper = 32'h8000_0000;
    drive(48'h0_8040_0000, "R1");
    idle();
    @(negedge clk);
    checks++;
    if (out_valid !== 0) begin
      errors++;
      $display("FAIL R2: actual out_valid=%0b expected 0 after idle", out_valid);
    end

    wr(8'd0, 8'h05); wr(8'd1, 8'h11); wr(8'd255, 8'hAB); wr(8'd128, 8'h42);
    drive(48'h0_8000_0000, "R3");
    drive(48'h0_8080_0000, "R5");
    drive(48'h0_C012_3456, "R5");
    drive(48'h0_FFFF_FFF0, "R8");
    drive(48'h0_FFFF_0004, "R8");
    drive(48'h0_7FFF_FFFF, "R7");
    drive(48'h1_8000_0000, "R3");
    idle();

    wr(8'h56, 8'h77);
    cfg_base = 48'h12_3400_0000; cfg_log2sz = 6'd24; cfg_upper = 32'hC0AB_CDEF;
    drive(48'h12_3456_7890, "R4");
    idle();
    cfg_base = 48'h12_3412_3456;
    drive(48'h12_3456_7890, "R3");
    drive(48'h12_3556_7890, "R7");
    idle();

    wr(8'hDE, 8'h3C);
    cfg_base = 48'h5_0000_0000; cfg_log2sz = 6'd32; cfg_upper = 32'h1234_5678;
    drive(48'h5_DEAD_BEEF, "R9");
    drive(48'h4_DEAD_BEEF, "R7");
    idle();

    wr(8'hA5, 8'h99);
    cfg_base = 48'h0_0000_0100; cfg_log2sz = 6'd8; cfg_upper = 32'h8000_0000;
    drive(48'h0_0000_01A5, "R5");
    @(negedge clk);
    in_valid = 1; in_addr = 48'h0_0000_01A5;
    tbl_we = 1; tbl_idx = 8'hA5; tbl_dom = 8'h66;
    exp_q.push_back(model(48'h0_0000_01A5));
    tag_q.push_back("R6");
    @(negedge clk);
    tbl_we = 0; in_valid = 0;
    shadow[8'hA5] = 8'h66;
    drive(48'h0_0000_01A5, "R6");
    drive(48'h0_0000_02A5, "R7");
    idle();

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2: actual %0d results missing expected 0", exp_q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule